// File: doc/BRIEF.md
# Paged edge-interrupt GPIO controller

This block provides 48 open-drain style digital lines, grouped as six 8-bit ports, behind a byte-wide register bus with a 16-byte address window. Each port offset reads back the synchronised pin levels and holds an output latch. A latch bit of 1 pulls its pin low. A latch bit of 0 leaves the pin undriven, so the pin can then be used as an input.

The 24 lines of ports 0 to 2 can raise edge-triggered interrupts. Three shared per-port registers sit at offsets 8 to 10. A page value written to offset 7 selects what they access: the per-pin enables, the per-pin edge polarities, or the read-only pending bits. Offset 6 gives one summary flag per interrupt-capable port. A single active-high interrupt line goes to the host. Software clears a pending event by writing its enable bit to 0 and then back to 1.

Top module: `edge_irq_gpio`

## Requirements
- R1: After reset, every output latch, enable bit, polarity bit and pending bit is 0, `pin_drive_low` is all 0, `irq` is 0, and offset 7 reads 0xC0.
- R2: A write to offset k (0 to 5) loads port k's latch. Latch bit j drives `pin_drive_low[8k+j]`. Reading offset k returns `pin_in[8k+7:8k]` after two clock edges of synchronisation.
- R3: Offset 7 reads back the page value last written. With page 0x80, offsets 8, 9 and 10 read and write the enable bytes of ports 0, 1 and 2. With page 0x40, they read and write the polarity bytes of the same ports.
- R4: For an enabled pin, a polarity bit of 1 makes a synchronised 0-to-1 transition set its pending bit. A polarity bit of 0 makes a 1-to-0 transition set it. A transition in the other direction sets nothing.
- R5: A transition on a pin whose enable bit is 0 never sets its pending bit.
- R6: With page 0xC0, offsets 8 to 10 return the pending bytes of ports 0 to 2. Offset 6 returns in bit p the OR of port p's pending bits, for p = 0 to 2, with bits 7:3 reading 0.
- R7: `irq` is high exactly when any pending bit is set.
- R8: A pending bit stays set after its pin returns to its old level. Writing its enable bit to 0 clears it. Writing the enable bit back to 1 re-arms detection without creating a new pending event.
- R9: Pins 24 to 47 never affect `irq` or any pending bit.
- R10: Writes to offsets 11 to 15 change nothing, and reads from them return 0. Writes to offsets 8 to 10 on page 0xC0 change no enable, polarity or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 48 | Pin levels seen at the pads |
| pin_drive_low | output | 48 | 1 pulls the matching pin low |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench drives rising and falling transitions against both polarity settings. A design with the polarity sense inverted would set pending bits on the wrong edges. One that ignored the enable would latch events on disabled pins.

It also returns a pin to its old level after an event. A design that followed the level instead of latching would drop the pending bit at that point.

The bench then clears one enable bit and sets it again. This exposes two faults: a clear that leaks to neighbouring bits, and a re-arm that replays a stale transition recorded while the pin was disabled. Toggling the upper 24 pins and writing to undefined or read-only locations catches address decode that aliases into live registers.

// File: rtl/edge_irq_gpio.sv
module edge_irq_gpio #(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wr_en,
  input  logic [PORT_W-1:0]             wr_data,
  output logic [PORT_W-1:0]             rd_data,
  input  logic [PORT_W*NUM_PORTS-1:0]   pin_in,
  output logic [PORT_W*NUM_PORTS-1:0]   pin_drive_low,
  output logic                          irq
);
  localparam int NPINS     = PORT_W * NUM_PORTS;
  localparam int NIRQ      = PORT_W * IRQ_PORTS;
  localparam int SUM_ADDR  = NUM_PORTS;
  localparam int PAGE_ADDR = NUM_PORTS + 1;
  localparam int BANK_ADDR = NUM_PORTS + 2;
  localparam int BANK_END  = BANK_ADDR + IRQ_PORTS;
  localparam logic [PORT_W-1:0] PG_EN   = PORT_W'(8'h80);
  localparam logic [PORT_W-1:0] PG_POL  = PORT_W'(8'h40);
  localparam logic [PORT_W-1:0] PG_NORM = PORT_W'(8'hC0);

  logic [NPINS-1:0]     latch, s1, s2;
  logic [NIRQ-1:0]      en, pol, pend, prev, hit, en_nx, lvl;
  logic [PORT_W-1:0]    page;
  logic [IRQ_PORTS-1:0] summ;

  wire in_bank  = int'(addr) >= BANK_ADDR && int'(addr) < BANK_END;
  wire en_wr    = wr_en && in_bank && page == PG_EN;
  wire pol_wr   = wr_en && in_bank && page == PG_POL;

  assign lvl = s2[NIRQ-1:0];
  assign hit = en & ((lvl & ~prev & pol) | (~lvl & prev & ~pol));

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq_port
    assign en_nx[p*PORT_W +: PORT_W] =
      (en_wr && int'(addr) == BANK_ADDR + p) ? wr_data : en[p*PORT_W +: PORT_W];
    assign summ[p] = |pend[p*PORT_W +: PORT_W];
  end

  assign irq           = |summ;
  assign pin_drive_low = latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '0;
      s1    <= '0;
      s2    <= '0;
      prev  <= '0;
      en    <= '0;
      pol   <= '0;
      pend  <= '0;
      page  <= PG_NORM;
    end else begin
      s1   <= pin_in;
      s2   <= s1;
      prev <= lvl;
      en   <= en_nx;
      pend <= (pend | hit) & en_nx;
      if (wr_en && int'(addr) == PAGE_ADDR) page <= wr_data;
      for (int p = 0; p < NUM_PORTS; p++)
        if (wr_en && int'(addr) == p) latch[p*PORT_W +: PORT_W] <= wr_data;
      for (int p = 0; p < IRQ_PORTS; p++)
        if (pol_wr && int'(addr) == BANK_ADDR + p) pol[p*PORT_W +: PORT_W] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (int'(addr) == p) rd_data = s2[p*PORT_W +: PORT_W];
    if (int'(addr) == SUM_ADDR)  rd_data = PORT_W'(summ);
    if (int'(addr) == PAGE_ADDR) rd_data = page;
    for (int p = 0; p < IRQ_PORTS; p++)
      if (int'(addr) == BANK_ADDR + p) begin
        if (page == PG_EN)        rd_data = en[p*PORT_W +: PORT_W];
        else if (page == PG_POL)  rd_data = pol[p*PORT_W +: PORT_W];
        else if (page == PG_NORM) rd_data = pend[p*PORT_W +: PORT_W];
      end
  end

  assert_quiet_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> ((pend & $past(pend)) == $past(pend)));

  assert_new_pending_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(en)) == '0));

  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && int'(addr) < NUM_PORTS) |=> $stable(pin_drive_low));

  assert_undef_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) >= BANK_END) |=> ($stable(page) && $stable(en) && $stable(pol)));

  assert_irq_tracks_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(pend) == '0));
endmodule

// File: tb/tb_edge_irq_gpio.sv
module tb_edge_irq_gpio;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = '0;
  logic        wr_en = 0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_drive_low;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  edge_irq_gpio dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_drive_low(pin_drive_low), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 4'(a);
    #1 d = rd_data;
  endtask

  task automatic pins(input logic [47:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 drive", pin_drive_low, 0);
    rd(7, d); chk("R1 page", d, 8'hC0);
    rd(6, d); chk("R1 summary", d, 0);
    wr(7, 8'h80);
    rd(8, d); chk("R1 enable", d, 0);
    wr(7, 8'h40);
    rd(10, d); chk("R1 polarity", d, 0);
    wr(7, 8'hC0);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    wr(0, 8'hA5); wr(5, 8'h3C);
    chk("R2 drive", pin_drive_low, {8'h3C, 32'h0, 8'hA5});
    pins(48'h123456789ABC);
    for (int k = 0; k < 6; k++) begin
      rd(k, d); chk("R2 readback", d, 8'(48'h123456789ABC >> (8*k)));
    end
    wr(0, 8'h00); wr(5, 8'h00);
    chk("R2 drive clear", pin_drive_low, 0);
    pins(48'h0);
  endtask

  task automatic t_pages();
    logic [7:0] d;
    wr(7, 8'h80); rd(7, d); chk("R3 page read", d, 8'h80);
    wr(8, 8'h11); wr(9, 8'h22); wr(10, 8'h33);
    rd(9, d); chk("R3 enable p1", d, 8'h22);
    wr(7, 8'h40);
    wr(8, 8'h44); wr(9, 8'h55); wr(10, 8'h66);
    rd(8, d); chk("R3 polarity p0", d, 8'h44);
    wr(7, 8'h80);
    rd(10, d); chk("R3 enable p2 kept", d, 8'h33);
    wr(8, 0); wr(9, 0); wr(10, 0);
    wr(7, 8'h40); wr(8, 0); wr(9, 0); wr(10, 0);
    wr(7, 8'hC0);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    pins(48'h000000_00000A);
    wr(7, 8'h40); wr(8, 8'h09);
    wr(7, 8'h80); wr(8, 8'h0B);
    wr(7, 8'hC0);
    rd(8, d); chk("R5 no stale pending", d, 0);
    pins(48'h000000_00000B);
    rd(8, d); chk("R4 rising", d, 8'h01);
    chk("R7 irq set", irq, 1);
    pins(48'h000000_000001);
    rd(8, d); chk("R4 falling, R4 opposite edge", d, 8'h03);
    pins(48'h000000_000005);
    rd(8, d); chk("R5 disabled pin", d, 8'h03);
    pins(48'h000000_000004);
    rd(8, d); chk("R8 sticky", d, 8'h03);
    rd(6, d); chk("R6 summary p0", d, 8'h01);
    wr(7, 8'h80); wr(8, 8'h0A);
    wr(7, 8'hC0);
    rd(8, d); chk("R8 clear bit0", d, 8'h02);
    wr(7, 8'h80); wr(8, 8'h0B);
    wr(7, 8'hC0);
    rd(8, d); chk("R8 rearm no event", d, 8'h02);
    wr(7, 8'h80); wr(8, 8'h00);
    wr(7, 8'hC0);
    rd(8, d); chk("R8 cleared all", d, 0);
    chk("R7 irq low", irq, 0);
    pins(48'h0);
  endtask

  task automatic t_port2();
    logic [7:0] d;
    wr(7, 8'h40); wr(10, 8'h80);
    wr(7, 8'h80); wr(10, 8'h80);
    wr(7, 8'hC0);
    pins(48'h000000_800000);
    rd(10, d); chk("R6 pending p2", d, 8'h80);
    rd(6, d);  chk("R6 summary p2", d, 8'h04);
    chk("R7 irq p2", irq, 1);
    wr(10, 8'h00);
    rd(10, d); chk("R10 normal page write ignored", d, 8'h80);
    wr(7, 8'h80); wr(10, 8'h00);
    wr(7, 8'h40); wr(10, 8'h00);
    wr(7, 8'hC0);
    chk("R7 irq cleared", irq, 0);
    pins(48'h0);
  endtask

  task automatic t_upper();
    logic [7:0] d;
    wr(7, 8'h80); wr(8, 8'hFF); wr(9, 8'hFF); wr(10, 8'hFF);
    wr(7, 8'hC0);
    pins(48'hFFFFFF_000000);
    pins(48'h0);
    chk("R9 irq", irq, 0);
    rd(6, d); chk("R9 summary", d, 0);
    wr(7, 8'h80); wr(8, 0); wr(9, 0); wr(10, 0);
    wr(7, 8'hC0);
  endtask

  task automatic t_undef();
    logic [7:0] d;
    for (int a = 11; a < 16; a++) wr(a, 8'hFF);
    for (int a = 11; a < 16; a++) begin
      rd(a, d); chk("R10 undef read", d, 0);
    end
    rd(7, d); chk("R10 page kept", d, 8'hC0);
    chk("R10 drive kept", pin_drive_low, 0);
    wr(7, 8'h80);
    rd(8, d); chk("R10 enable kept", d, 0);
    wr(7, 8'hC0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ports();
    t_pages();
    t_edges();
    t_port2();
    t_upper();
    t_undef();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule